// File: doc/BRIEF.md
# Receive Loss Event Counters

This block tallies two kinds of lost receive frames for a DMA receive path. One counter records frames dropped because no receive buffer was free. The other records frames dropped because the receive FIFO overflowed. Each detector delivers a one-cycle pulse per lost frame. Both pulses may arrive in the same cycle, and each is counted separately.

Both counts, together with a sticky overflow flag for each count, are packed into one 32-bit status word. The word is always visible and is cleared when it is read. The register interface shows the word while it asserts a one-cycle read strobe, and the block empties both counters and both flags at that edge. An event that arrives in the read cycle is never lost: it becomes the first count of the new interval. A word of all zeros means no loss of either kind since the last read. All pins are plain control and status signals. There is no streaming interface, so there is no back-pressure.

Top module: `rx_loss_counters`

## Requirements
- R1: After reset the status word is 0x00000000.
- R2: Each cycle with buffer_miss_evt high and no read adds 1 to the buffer-miss count in bits [15:0]. The new value is visible in the cycle after the pulse.
- R3: Each cycle with fifo_ovf_evt high and no read adds 1 to the FIFO-overflow count in bits [27:17]. The new value is visible in the cycle after the pulse.
- R4: The buffer-miss count saturates at 0xFFFF. A buffer-miss event that arrives while the count is 0xFFFF sets bit 16. That bit then stays set, and the count stays at 0xFFFF, until the next read.
- R5: The FIFO-overflow count saturates at 0x7FF. The 2048th event sets bit 28. That bit then stays set, and the count stays at 0x7FF, until the next read.
- R6: During the cycle in which read_stb is high, status_word shows the accumulated values. If no event arrives in that cycle, the whole word is 0 in the following cycle.
- R7: An event that coincides with read_stb leaves its count at exactly 1 after the read, with its overflow flag cleared.
- R8: Pulses on both event inputs in the same cycle advance both counts by 1 each.
- R9: Bits [31:29] of status_word always read as 0.
- R10: In a cycle with no event and no read, status_word does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buffer_miss_evt | input | 1 | One-cycle pulse: frame lost for lack of a receive buffer |
| fifo_ovf_evt | input | 1 | One-cycle pulse: frame lost to receive FIFO overflow |
| read_stb | input | 1 | One-cycle read strobe; clears counts and flags at the edge |
| status_word | output | 32 | Packed counts and overflow flags |

## Verification
Single pulses on each input show that each count lands in its own field and not in the other's. Simultaneous pulses separate independent counting from shared or priority logic. Long continuous bursts drive each counter through its last value and past it, which shows the difference between saturating with a sticky flag and wrapping to zero. Reads with and without a coinciding event show whether a read can lose an event, and whether it clears the flags as well as the counts.

// File: rtl/rx_loss_pkg.sv
package rx_loss_pkg;
  localparam int MISS_W_DEF = 16;
  localparam int OVF_W_DEF  = 11;
  localparam int WORD_W_DEF = 32;

  typedef enum logic [1:0] {
    CNT_IDLE  = 2'd0,
    CNT_INC   = 2'd1,
    CNT_SAT   = 2'd2,
    CNT_CLEAR = 2'd3
  } cnt_action_e;
endpackage

// File: rtl/sat_event_counter.sv
module sat_event_counter
  import rx_loss_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt,
  input  logic         clr,
  output logic [W-1:0] count,
  output logic         sat_flag
);
  localparam logic [W-1:0] MAX_VAL = {W{1'b1}};
  localparam logic [W-1:0] ONE_VAL = W'(1);

  cnt_action_e action;

  always_comb begin
    if (clr)                       action = CNT_CLEAR;
    else if (evt && count == MAX_VAL) action = CNT_SAT;
    else if (evt)                  action = CNT_INC;
    else                           action = CNT_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      sat_flag <= 1'b0;
    end else begin
      unique case (action)
        CNT_CLEAR: begin
          // an event in the read cycle opens the new interval
          count    <= evt ? ONE_VAL : '0;
          sat_flag <= 1'b0;
        end
        CNT_SAT:  sat_flag <= 1'b1;
        CNT_INC:  count    <= count + ONE_VAL;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/loss_word_packer.sv
module loss_word_packer #(
  parameter int MISS_W = 16,
  parameter int OVF_W  = 11,
  parameter int WORD_W = 32
) (
  input  logic [MISS_W-1:0] miss_cnt,
  input  logic              miss_sat,
  input  logic [OVF_W-1:0]  ovf_cnt,
  input  logic              ovf_sat,
  output logic [WORD_W-1:0] word
);
  localparam int MISS_FLAG_POS = MISS_W;
  localparam int OVF_LSB       = MISS_W + 1;
  localparam int OVF_FLAG_POS  = OVF_LSB + OVF_W;
  localparam int USED_W        = OVF_FLAG_POS + 1;

  always_comb begin
    word = '0;
    word[MISS_W-1:0]                  = miss_cnt;
    word[MISS_FLAG_POS]               = miss_sat;
    word[OVF_LSB +: OVF_W]            = ovf_cnt;
    word[OVF_FLAG_POS]                = ovf_sat;
  end

  if (USED_W > WORD_W) begin : g_bad_width
    initial $error("status word too narrow for the two counters");
  end
endmodule

// File: rtl/rx_loss_counters.sv
module rx_loss_counters
  import rx_loss_pkg::*;
#(
  parameter int MISS_W = MISS_W_DEF,
  parameter int OVF_W  = OVF_W_DEF,
  parameter int WORD_W = WORD_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buffer_miss_evt,
  input  logic              fifo_ovf_evt,
  input  logic              read_stb,
  output logic [WORD_W-1:0] status_word
);
  logic [MISS_W-1:0] miss_cnt;
  logic              miss_sat;
  logic [OVF_W-1:0]  ovf_cnt;
  logic              ovf_sat;

  sat_event_counter #(.W(MISS_W)) u_miss_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (buffer_miss_evt),
    .clr      (read_stb),
    .count    (miss_cnt),
    .sat_flag (miss_sat)
  );

  sat_event_counter #(.W(OVF_W)) u_ovf_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (fifo_ovf_evt),
    .clr      (read_stb),
    .count    (ovf_cnt),
    .sat_flag (ovf_sat)
  );

  loss_word_packer #(.MISS_W(MISS_W), .OVF_W(OVF_W), .WORD_W(WORD_W)) u_pack (
    .miss_cnt (miss_cnt),
    .miss_sat (miss_sat),
    .ovf_cnt  (ovf_cnt),
    .ovf_sat  (ovf_sat),
    .word     (status_word)
  );
endmodule

// File: rtl/rx_loss_counters_checker.sv
module rx_loss_counters_checker #(
  parameter int MISS_W = 16,
  parameter int OVF_W  = 11,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              buffer_miss_evt,
  input logic              fifo_ovf_evt,
  input logic              read_stb,
  input logic [WORD_W-1:0] status_word
);
  localparam int OVF_LSB = MISS_W + 1;
  localparam int OVF_FP  = OVF_LSB + OVF_W;
  localparam logic [MISS_W-1:0] MMAX = {MISS_W{1'b1}};
  localparam logic [OVF_W-1:0]  OMAX = {OVF_W{1'b1}};

  logic [MISS_W-1:0] m_cnt;
  logic [OVF_W-1:0]  o_cnt;
  logic              m_flag;
  logic              o_flag;
  assign m_cnt  = status_word[MISS_W-1:0];
  assign m_flag = status_word[MISS_W];
  assign o_cnt  = status_word[OVF_LSB +: OVF_W];
  assign o_flag = status_word[OVF_FP];

  assert_spare_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[WORD_W-1:OVF_FP+1] == '0);

  assert_miss_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!read_stb && buffer_miss_evt && m_cnt != MMAX) |=> m_cnt == MISS_W'($past(m_cnt) + 1'b1));

  assert_ovf_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!read_stb && fifo_ovf_evt && o_cnt != OMAX) |=> o_cnt == OVF_W'($past(o_cnt) + 1'b1));

  assert_miss_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!read_stb && m_flag) |=> (m_flag && m_cnt == MMAX));

  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!read_stb && o_flag) |=> (o_flag && o_cnt == OMAX));

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (read_stb && !buffer_miss_evt && !fifo_ovf_evt) |=> status_word == '0);

  assert_read_keeps_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (read_stb && buffer_miss_evt) |=> (m_cnt == MISS_W'(1) && !m_flag));

  assert_quiet_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!read_stb && !buffer_miss_evt && !fifo_ovf_evt) |=> $stable(status_word));
endmodule

bind rx_loss_counters rx_loss_counters_checker #(
  .MISS_W(MISS_W), .OVF_W(OVF_W), .WORD_W(WORD_W)
) u_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .buffer_miss_evt (buffer_miss_evt),
  .fifo_ovf_evt    (fifo_ovf_evt),
  .read_stb        (read_stb),
  .status_word     (status_word)
);

// File: tb/rx_loss_counters_bench.sv
`timescale 1ns/1ps
module rx_loss_counters_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss = 1'b0;
  logic        ovf = 1'b0;
  logic        rd = 1'b0;
  logic [31:0] word;
  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  rx_loss_counters u_rx_loss_counters (
    .clk             (clk),
    .rst_n           (rst_n),
    .buffer_miss_evt (miss),
    .fifo_ovf_evt    (ovf),
    .read_stb        (rd),
    .status_word     (word)
  );

  function automatic logic [31:0] pack(input logic [15:0] mc, input logic mf,
                                       input logic [10:0] oc, input logic of);
    return {3'b000, of, oc, mf, mc};
  endfunction

  task automatic check(input string req, input logic [31:0] exp);
    n_checks++;
    if (word !== exp) begin
      n_errors++;
      $display("FAIL %s: status_word actual=%08h expected=%08h", req, word, exp);
    end
  endtask

  // drive one cycle at the falling edge, return at the next falling edge
  task automatic cyc(input logic m, input logic o, input logic r);
    miss = m; ovf = o; rd = r;
    @(negedge clk);
    miss = 1'b0; ovf = 1'b0; rd = 1'b0;
  endtask

  task automatic do_read();
    cyc(1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_reset();
    check("R1", 32'h0);
    check("R9", 32'h0);
  endtask

  task automatic t_single();
    cyc(1, 0, 0); check("R2", pack(16'd1, 0, 11'd0, 0));
    cyc(1, 0, 0); cyc(1, 0, 0); check("R2", pack(16'd3, 0, 11'd0, 0));
    cyc(0, 1, 0); check("R3", pack(16'd3, 0, 11'd1, 0));
    cyc(0, 0, 0); cyc(0, 0, 0); check("R10", pack(16'd3, 0, 11'd1, 0));
  endtask

  task automatic t_both();
    cyc(1, 1, 0); cyc(1, 1, 0); check("R8", pack(16'd5, 0, 11'd3, 0));
  endtask

  task automatic t_read();
    miss = 0; ovf = 0; rd = 1;
    #1 check("R6", pack(16'd5, 0, 11'd3, 0));
    @(negedge clk); rd = 0;
    check("R6", 32'h0);
  endtask

  task automatic t_read_event();
    cyc(1, 1, 0); cyc(1, 0, 0);
    cyc(1, 1, 1); check("R7", pack(16'd1, 0, 11'd1, 0));
    do_read(); check("R6", 32'h0);
  endtask

  task automatic t_miss_sat();
    miss = 1;
    for (int i = 0; i < 65535; i++) @(negedge clk);
    miss = 0;
    check("R4", pack(16'hFFFF, 0, 11'd0, 0));
    cyc(1, 0, 0); check("R4", pack(16'hFFFF, 1, 11'd0, 0));
    cyc(1, 0, 0); cyc(0, 0, 0); check("R4", pack(16'hFFFF, 1, 11'd0, 0));
    cyc(1, 0, 1); check("R7", pack(16'd1, 0, 11'd0, 0));
    do_read();
  endtask

  task automatic t_ovf_sat();
    ovf = 1;
    for (int i = 0; i < 2047; i++) @(negedge clk);
    ovf = 0;
    check("R5", pack(16'd0, 0, 11'h7FF, 0));
    cyc(0, 1, 0); check("R5", pack(16'd0, 0, 11'h7FF, 1));
    cyc(1, 1, 0); check("R5", pack(16'd1, 0, 11'h7FF, 1));
    check("R9", pack(16'd1, 0, 11'h7FF, 1));
    do_read(); check("R6", 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_both();
    t_read();
    t_read_event();
    t_miss_sat();
    t_ovf_sat();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule